// File: doc/BRIEF.md
# Dual-Interval Watchdog Timer

This block supervises a processor or controller by expecting a periodic sign of life. It counts millisecond ticks from an external timebase. Software programs two intervals. A start interval covers the first period after the watchdog is armed. A steady interval covers every period after that. Each kick restarts the count. A kick is either a rising edge on an asynchronous pin or a non-zero write to the steady-interval register. If a count reaches its limit, the block raises a sticky alert. It can also hold the supply's power-good indication low for a programmed number of milliseconds before letting it rise again.

The watchdog has two arming modes. In the free mode, the start interval begins as soon as both interval registers hold non-zero values. In the power-good-linked mode, the start interval begins only on a rising edge of the internal power-good input, and the watchdog rests while that input is low. Writing zero to either interval register turns the watchdog off.

Top module: `dual_wdt`

## Requirements
- R1: After reset, `alert_o` and `pg_force_low_o` are 0 and all four registers read back 0.
- R2: The register port has four 16-bit registers, each of which reads back exactly what was last written. Address 0 is the start interval in ms. Address 1 is the steady interval in ms. Address 2 is control: bit 0 enables the power-good bounce, and bit 1 selects power-good-linked arming. Address 3 is the bounce hold time in ms. `rd_data_o` shows the register selected by `reg_addr_i` in the same cycle.
- R3: While either interval register holds zero, the watchdog does not expire and `alert_o` never rises. Making both registers non-zero again in the free mode starts a fresh start interval.
- R4: In the free mode, the first expiry occurs on the N-th `ms_tick_i` pulse after the watchdog becomes enabled, where N is the start-interval value. `alert_o` is high in the cycle after that tick.
- R5: After an expiry, the count restarts, and each following expiry occurs after the steady-interval number of ticks.
- R6: In the power-good-linked mode, the watchdog rests while `pg_int_i` is low. A rising edge of `pg_int_i` starts the start interval; this is the only way the start interval is re-armed. The steady interval applies after the first expiry.
- R7: A rising edge on `kick_pin_i` is synchronized through two flops. Three clocks after the edge it has restarted the count, and the steady interval applies from then on.
- R8: A write of a non-zero value to the steady-interval register restarts the count. A write of zero to it disables the watchdog.
- R9: `alert_o` rises on expiry and stays high until `clr_alert_i` is pulsed. An expiry in the same cycle as the clear wins.
- R10: With control bit 0 set, an expiry drives `pg_force_low_o` high. It drops on the H-th tick after the expiry, where H is the hold value (a hold of 0 acts as 1). With bit 0 clear, `pg_force_low_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for write and read |
| reg_wdata_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Read data of the addressed register |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| kick_pin_i | input | 1 | Asynchronous kick input, active on rising edge |
| pg_int_i | input | 1 | Internal power-good level |
| clr_alert_i | input | 1 | Clears the alert |
| alert_o | output | 1 | Sticky expiry alert |
| pg_force_low_o | output | 1 | Holds power-good low during a bounce |

## Verification
Expiry is tied to the tick that brings the elapsed count to the interval, so `alert_o` and `pg_force_low_o` are sampled on the falling edge right after that tick's rising edge. They are also checked one tick earlier to prove the expiry is not premature. The kick pin path is three registers deep, so the bench waits five clocks after a pin edge before issuing ticks, and keeps ticks apart from kicks and power-good edges. Register reads are combinational and are checked one time step after the address changes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] A_FIRST  = 2'd0;
   localparam logic [ADDR_W-1:0] A_PERIOD = 2'd1;
   localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
   localparam logic [ADDR_W-1:0] A_HOLD   = 2'd3;
   localparam int CTRL_BOUNCE = 0;
   localparam int CTRL_GATED  = 1;

   typedef enum logic [1:0] {
      PH_OFF    = 2'd0,
      PH_FIRST  = 2'd1,
      PH_STEADY = 2'd2
   } phase_e;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
   import wdt_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   rdata_o,
   output logic [DATA_W-1:0]   first_o,
   output logic [DATA_W-1:0]   period_o,
   output logic [DATA_W-1:0]   hold_o,
   output logic                bounce_en_o,
   output logic                gated_o,
   output logic                period_kick_o
);
   logic [DATA_W-1:0] first_q, period_q, ctrl_q, hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q  <= '0;
         period_q <= '0;
         ctrl_q   <= '0;
         hold_q   <= '0;
      end else if (wr_i) begin
         case (addr_i)
            A_FIRST:  first_q  <= wdata_i;
            A_PERIOD: period_q <= wdata_i;
            A_CTRL:   ctrl_q   <= wdata_i;
            default:  hold_q   <= wdata_i;
         endcase
      end
   end

   always_comb begin
      case (addr_i)
         A_FIRST:  rdata_o = first_q;
         A_PERIOD: rdata_o = period_q;
         A_CTRL:   rdata_o = ctrl_q;
         default:  rdata_o = hold_q;
      endcase
   end

   assign first_o       = first_q;
   assign period_o      = period_q;
   assign hold_o        = hold_q;
   assign bounce_en_o   = ctrl_q[CTRL_BOUNCE];
   assign gated_o       = ctrl_q[CTRL_GATED];
   assign period_kick_o = wr_i && (addr_i == A_PERIOD) && (wdata_i != '0);

   p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == A_FIRST) |=> (first_q == $past(wdata_i)));
endmodule

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("wdt_kick_sync needs at least two stages");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= pin_i;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[LAST];
   end

   assign rise_o = sync_q[LAST] & ~prev_q;

   p_kick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/wdt_interval_ctr.sv
module wdt_interval_ctr
   import wdt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             enabled_i,
   input  logic             gated_i,
   input  logic             pg_level_i,
   input  logic             pg_rise_i,
   input  logic             kick_i,
   input  logic [CNT_W-1:0] first_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             expire_o
);
   phase_e           phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W:0]   cnt_inc, limit;

   assign limit   = {1'b0, (phase_q == PH_FIRST) ? first_i : period_i};
   assign cnt_inc = {1'b0, cnt_q} + 1'b1;

   always_comb begin
      phase_d  = phase_q;
      cnt_d    = cnt_q;
      expire_o = 1'b0;
      if (!enabled_i) begin
         phase_d = PH_OFF;
         cnt_d   = '0;
      end else if (phase_q == PH_OFF) begin
         if (!gated_i || pg_rise_i) begin
            phase_d = PH_FIRST;
            cnt_d   = '0;
         end
      end else if (gated_i && !pg_level_i) begin
         phase_d = PH_OFF;
         cnt_d   = '0;
      end else if (gated_i && pg_rise_i) begin
         phase_d = PH_FIRST;
         cnt_d   = '0;
      end else if (kick_i) begin
         phase_d = PH_STEADY;
         cnt_d   = '0;
      end else if (tick_i) begin
         if (cnt_inc >= limit) begin
            expire_o = 1'b1;
            phase_d  = PH_STEADY;
            cnt_d    = '0;
         end else begin
            cnt_d = cnt_inc[CNT_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   p_off_no_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled_i |-> !expire_o);
   p_kick_clears_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kick_i |=> (cnt_q == '0));
   p_gated_rest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gated_i && phase_q == PH_OFF && !pg_rise_i) |=> (phase_q == PH_OFF));
   p_steady_after_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> (phase_q == PH_STEADY));
endmodule

// File: rtl/wdt_pg_bounce.sv
module wdt_pg_bounce #(
   parameter int DLY_W      = 16,
   parameter bit HAS_BOUNCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             expire_i,
   input  logic             enable_i,
   input  logic [DLY_W-1:0] hold_i,
   output logic             force_o
);
   if (DLY_W < 1) begin : g_bad_width
      $error("wdt_pg_bounce needs a non-zero hold width");
   end

   if (HAS_BOUNCE) begin : g_bounce
      logic             force_q;
      logic [DLY_W-1:0] dcnt_q;
      logic [DLY_W:0]   dnext, dlim;

      assign dnext = {1'b0, dcnt_q} + 1'b1;
      assign dlim  = (hold_i == '0) ? {{DLY_W{1'b0}}, 1'b1} : {1'b0, hold_i};

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            force_q <= 1'b0;
            dcnt_q  <= '0;
         end else if (expire_i && enable_i) begin
            force_q <= 1'b1;
            dcnt_q  <= '0;
         end else if (force_q && tick_i) begin
            if (dnext >= dlim) begin
               force_q <= 1'b0;
               dcnt_q  <= '0;
            end else begin
               dcnt_q <= dnext[DLY_W-1:0];
            end
         end
      end

      assign force_o = force_q;

      p_force_from_expiry_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(force_q) |-> $past(expire_i && enable_i));
      p_force_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (force_q && !tick_i) |=> force_q);
   end else begin : g_no_bounce
      assign force_o = 1'b0;
   end
endmodule

// File: rtl/dual_wdt.sv
module dual_wdt
   import wdt_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_BOUNCE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [1:0]        reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              ms_tick_i,
   input  logic              kick_pin_i,
   input  logic              pg_int_i,
   input  logic              clr_alert_i,
   output logic              alert_o,
   output logic              pg_force_low_o
);
   if (DATA_W < 2) begin : g_bad_data
      $error("dual_wdt needs DATA_W of at least 2");
   end

   logic [DATA_W-1:0] first_w, period_w, hold_w;
   logic bounce_en, gated, wr_kick, pin_kick, kick, enabled;
   logic pg_q, pg_rise, expire, alert_q;

   wdt_regfile #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .rdata_o(rd_data_o), .first_o(first_w),
      .period_o(period_w), .hold_o(hold_w), .bounce_en_o(bounce_en),
      .gated_o(gated), .period_kick_o(wr_kick)
   );

   wdt_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(kick_pin_i), .rise_o(pin_kick)
   );

   assign kick    = pin_kick | wr_kick;
   assign enabled = (first_w != '0) && (period_w != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pg_q <= 1'b0;
      else        pg_q <= pg_int_i;
   end
   assign pg_rise = pg_int_i & ~pg_q;

   wdt_interval_ctr #(.CNT_W(DATA_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .tick_i(ms_tick_i), .enabled_i(enabled),
      .gated_i(gated), .pg_level_i(pg_int_i), .pg_rise_i(pg_rise),
      .kick_i(kick), .first_i(first_w), .period_i(period_w),
      .expire_o(expire)
   );

   wdt_pg_bounce #(.DLY_W(DATA_W), .HAS_BOUNCE(HAS_BOUNCE)) u_bounce (
      .clk(clk), .rst_n(rst_n), .tick_i(ms_tick_i), .expire_i(expire),
      .enable_i(bounce_en), .hold_i(hold_w), .force_o(pg_force_low_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           alert_q <= 1'b0;
      else if (expire)      alert_q <= 1'b1;
      else if (clr_alert_i) alert_q <= 1'b0;
   end
   assign alert_o = alert_q;

   p_expire_sets_alert_r9: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> alert_o);
   p_alert_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (alert_o && !clr_alert_i) |=> alert_o);
   p_alert_needs_expiry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alert_o) |-> $past(expire));
endmodule

// File: tb/dual_wdt_tb_top.sv
module dual_wdt_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] rd_data;
   logic ms_tick = 1'b0, kick_pin = 1'b0, pg_int = 1'b0, clr_alert = 1'b0;
   logic alert, pg_force_low;
   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   dual_wdt dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
      .reg_wdata_i(reg_wdata), .rd_data_o(rd_data), .ms_tick_i(ms_tick),
      .kick_pin_i(kick_pin), .pg_int_i(pg_int), .clr_alert_i(clr_alert),
      .alert_o(alert), .pg_force_low_o(pg_force_low)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [1:0] a, input int exp);
      @(negedge clk);
      reg_addr = a;
      #1 check(req, int'(rd_data), exp);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ms_tick = 1'b1;
         @(negedge clk); ms_tick = 1'b0;
         idle(1);
      end
   endtask

   task automatic clear_alert();
      @(negedge clk); clr_alert = 1'b1;
      @(negedge clk); clr_alert = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 alert", int'(alert), 0);
      check("R1 force", int'(pg_force_low), 0);
      for (int a = 0; a < 4; a++) rd_check("R1 reg", 2'(a), 0);
   endtask

   task automatic t_readback();
      wr(2'd0, 16'hA5C3); wr(2'd1, 16'h0F0E); wr(2'd2, 16'h0000); wr(2'd3, 16'h1234);
      rd_check("R2 first", 2'd0, 16'hA5C3);
      rd_check("R2 period", 2'd1, 16'h0F0E);
      rd_check("R2 ctrl", 2'd2, 0);
      rd_check("R2 hold", 2'd3, 16'h1234);
      wr(2'd0, 16'd0); wr(2'd1, 16'd0);
   endtask

   task automatic t_free_run();
      wr(2'd0, 16'd4); wr(2'd1, 16'd3); idle(3);
      ticks(3); check("R4 before first", int'(alert), 0);
      ticks(1); check("R4 first expiry", int'(alert), 1);
      check("R10 no bounce when off", int'(pg_force_low), 0);
      idle(4); check("R9 alert sticky", int'(alert), 1);
      clear_alert(); check("R9 cleared", int'(alert), 0);
      ticks(2); check("R5 before steady", int'(alert), 0);
      ticks(1); check("R5 steady expiry", int'(alert), 1);
      clear_alert();
   endtask

   task automatic t_pin_kick();
      ticks(2);
      @(negedge clk); kick_pin = 1'b1; idle(5);
      ticks(2); check("R7 kicked no expiry", int'(alert), 0);
      ticks(1); check("R7 expiry after kick", int'(alert), 1);
      kick_pin = 1'b0; clear_alert(); idle(4);
   endtask

   task automatic t_write_kick();
      ticks(2); wr(2'd1, 16'd3); idle(2);
      ticks(2); check("R8 write kick no expiry", int'(alert), 0);
      ticks(1); check("R8 expiry after write kick", int'(alert), 1);
      clear_alert();
   endtask

   task automatic t_disable();
      wr(2'd0, 16'd0); ticks(8); check("R3 first zero disables", int'(alert), 0);
      wr(2'd0, 16'd2); idle(2);
      ticks(1); check("R3 re-enabled start", int'(alert), 0);
      ticks(1); check("R3 re-enabled expiry", int'(alert), 1);
      clear_alert();
      wr(2'd1, 16'd0); ticks(8); check("R8 zero period disables", int'(alert), 0);
   endtask

   task automatic t_gated();
      pg_int = 1'b0;
      wr(2'd2, 16'd2); wr(2'd0, 16'd3); wr(2'd1, 16'd5);
      ticks(8); check("R6 rests while pg low", int'(alert), 0);
      @(negedge clk); pg_int = 1'b1; idle(2);
      ticks(2); check("R6 start interval pending", int'(alert), 0);
      ticks(1); check("R6 start interval expiry", int'(alert), 1);
      clear_alert();
      ticks(4); check("R6 steady pending", int'(alert), 0);
      ticks(1); check("R6 steady expiry", int'(alert), 1);
      clear_alert();
      @(negedge clk); pg_int = 1'b0;
      ticks(8); check("R6 rests again", int'(alert), 0);
      @(negedge clk); pg_int = 1'b1; idle(2);
      ticks(3); check("R6 re-armed start interval", int'(alert), 1);
      clear_alert();
   endtask

   task automatic t_bounce();
      wr(2'd2, 16'd3); wr(2'd3, 16'd2);
      @(negedge clk); pg_int = 1'b0; idle(2);
      @(negedge clk); pg_int = 1'b1; idle(2);
      ticks(2); check("R10 no force early", int'(pg_force_low), 0);
      ticks(1);
      check("R10 alert on expiry", int'(alert), 1);
      check("R10 force on expiry", int'(pg_force_low), 1);
      idle(3); check("R10 force held", int'(pg_force_low), 1);
      ticks(1); check("R10 force one tick", int'(pg_force_low), 1);
      ticks(1); check("R10 force released", int'(pg_force_low), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      t_reset();
      t_readback();
      t_free_run();
      t_pin_kick();
      t_write_kick();
      t_disable();
      t_gated();
      t_bounce();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule